// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block owns the four threshold offsets that a bidirectional FIFO pair uses for its almost-empty and almost-full flags. When the port A reset is released, it reads three mode pins once and settles on one of three ways to fill the offsets. The first way loads one of three fixed constants. The second takes the first four words written on port A. The third shifts in a bit-serial stream on the port A clock. The flag comparators and the storage RAM sit outside and only consume the four offset outputs.

While the offsets are being loaded, the block keeps the port A write path away from the FIFO RAM. It also holds both input-ready indications low. Port A ready is produced in the port A clock domain. Port B ready is a two-flop resynchronised copy of the completion state, clocked by the port B clock. The offset width is a parameter; the preset constants need at least 7 bits.

Top module: `ofs_prog_ctrl`

## Requirements
- R1: The load mode is taken from {prog_sel, fsel_hi, fsel_lo} on the first clk_a rising edge after rst_a_n goes high. Later changes on those pins have no effect on the offsets or on the ready outputs.
- R2: Codes 111, 110 and 101 load all four offsets with 64, 16 and 8 respectively on the capture edge. ready_a rises on the following clk_a edge.
- R3: Code 100 selects word loading. A write is accepted when wr_en_a and ready_a are both high at a clk_a edge, and ready_a rises on the second edge after release. The accepted writes fill ofs_af_a, ofs_ae_b, ofs_af_b and ofs_ae_a, in that order, from wr_data_a. A write made while ready_a is low changes nothing.
- R4: The four load writes never assert fifo_wr_en. Once the fourth has been taken, fifo_wr_en equals wr_en_a AND ready_a in every cycle.
- R5: Code 010 selects serial loading. On each clk_a edge with ser_en_n low, one bit of ser_din is taken; edges with ser_en_n high are ignored. After 4·W bits, the first bit taken is the MSB of ofs_af_a. The stream continues through ofs_ae_b and ofs_af_b, and its last bit is the LSB of ofs_ae_a.
- R6: During serial loading ready_a stays low and fifo_wr_en stays low. ready_a goes high on the clk_a edge after the edge that takes the last bit.
- R7: ready_b is low until loading completes. It is still low after the first clk_b edge following completion, and high from the third edge onwards.
- R8: Codes 000, 001 and 011 are reserved. In these codes all offsets stay zero, and ready_a, ready_b and fifo_wr_en never go high.
- R9: While rst_a_n and rst_b_n are low, all offsets read zero and ready_a, ready_b and fifo_wr_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A domain reset, asynchronous, active low |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B domain reset, asynchronous, active low |
| prog_sel | input | 1 | Mode pin: programmed or preset select |
| fsel_hi | input | 1 | Mode pin, upper select bit |
| fsel_lo | input | 1 | Mode pin, lower select bit |
| wr_en_a | input | 1 | Port A write strobe |
| wr_data_a | input | W | Port A write data, low bits |
| ser_din | input | 1 | Serial offset data |
| ser_en_n | input | 1 | Serial shift enable, active low |
| fifo_wr_en | output | 1 | Write forwarded to the FIFO RAM |
| ready_a | output | 1 | Port A input ready |
| ready_b | output | 1 | Port B input ready, clk_b domain |
| ofs_ae_b | output | W | Offset for port B almost-empty |
| ofs_ae_a | output | W | Offset for port A almost-empty |
| ofs_af_a | output | W | Offset for port A almost-full |
| ofs_af_b | output | W | Offset for port B almost-full |

## Verification
Most internal faults show up at the ports within one clk_a cycle. A wrong sequencing state leaves ready_a at the wrong level. A word counter that is off by one puts data into the wrong offset output or forwards a load write on fifo_wr_en. A serial chain that is misordered or mis-counted shows as wrong offset values, or as ready_a rising at the wrong edge, right when the stream ends. A faulty port B synchroniser shows within three clk_b edges after completion. The bench runs a behavioural model next to the design and compares the outputs on every clk_a cycle.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
  localparam int unsigned NUM_OFS = 4;

  typedef enum logic [2:0] {
    MODE_P64,
    MODE_P16,
    MODE_P8,
    MODE_WORD,
    MODE_BITS,
    MODE_RSV
  } ofs_mode_e;

  typedef enum logic [2:0] {
    ST_CAPTURE,
    ST_WORD,
    ST_BITS,
    ST_DONE,
    ST_HALT
  } ofs_state_e;
endpackage

// File: rtl/ofs_mode_decode.sv
module ofs_mode_decode
  import ofs_prog_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         prog_sel,
  input  logic         fsel_hi,
  input  logic         fsel_lo,
  output ofs_mode_e    mode,
  output logic [W-1:0] preset_val
);
  always_comb begin
    unique case ({prog_sel, fsel_hi, fsel_lo})
      3'b111:  mode = MODE_P64;
      3'b110:  mode = MODE_P16;
      3'b101:  mode = MODE_P8;
      3'b100:  mode = MODE_WORD;
      3'b010:  mode = MODE_BITS;
      default: mode = MODE_RSV;
    endcase
  end

  // Constants need W >= 7 to hold 64.
  always_comb begin
    unique case (mode)
      MODE_P64: preset_val = W'(64);
      MODE_P16: preset_val = W'(16);
      MODE_P8:  preset_val = W'(8);
      default:  preset_val = '0;
    endcase
  end
endmodule

// File: rtl/ofs_reg_bank.sv
module ofs_reg_bank
  import ofs_prog_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         preset_en,
  input  logic [W-1:0] preset_val,
  input  logic         word_en,
  input  logic [1:0]   word_idx,
  input  logic [W-1:0] word_data,
  input  logic         bit_en,
  input  logic         bit_in,
  output logic [W-1:0] ofs_y1,
  output logic [W-1:0] ofs_x1,
  output logic [W-1:0] ofs_y2,
  output logic [W-1:0] ofs_x2
);
  localparam int unsigned CHAIN = NUM_OFS * W;

  // slot 0 = Y1 (first loaded), 1 = X1, 2 = Y2, 3 = X2 (last loaded)
  logic [W-1:0]     slot_q [NUM_OFS];
  logic [W-1:0]     slot_d [NUM_OFS];
  logic [CHAIN-1:0] chain_q;
  logic [CHAIN-1:0] chain_sh;
  logic             load_any;

  for (genvar g = 0; g < NUM_OFS; g++) begin : g_chain
    assign chain_q[CHAIN-1-g*W -: W] = slot_q[g];
  end

  assign chain_sh = {chain_q[CHAIN-2:0], bit_in};
  assign load_any = preset_en | word_en | bit_en;

  always_comb begin
    slot_d = slot_q;
    if (preset_en) begin
      for (int i = 0; i < NUM_OFS; i++) slot_d[i] = preset_val;
    end else if (word_en) begin
      slot_d[word_idx] = word_data;
    end else if (bit_en) begin
      for (int i = 0; i < NUM_OFS; i++) slot_d[i] = chain_sh[CHAIN-1-i*W -: W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_OFS; i++) slot_q[i] <= '0;
    end else if (load_any) begin
      slot_q <= slot_d;
    end
  end

  assign ofs_y1 = slot_q[0];
  assign ofs_x1 = slot_q[1];
  assign ofs_y2 = slot_q[2];
  assign ofs_x2 = slot_q[3];

  AST_ONE_LOAD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({preset_en, word_en, bit_en})); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_any |=> $stable(chain_q)); // R8
endmodule

// File: rtl/ofs_sync_stage.sv
module ofs_sync_stage #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];

  AST_RDYB_FOLLOWS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(d, STAGES-1)); // R7
endmodule

// File: rtl/ofs_prog_ctrl.sv
module ofs_prog_ctrl
  import ofs_prog_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_a,
  input  logic         rst_a_n,
  input  logic         clk_b,
  input  logic         rst_b_n,
  input  logic         prog_sel,
  input  logic         fsel_hi,
  input  logic         fsel_lo,
  input  logic         wr_en_a,
  input  logic [W-1:0] wr_data_a,
  input  logic         ser_din,
  input  logic         ser_en_n,
  output logic         fifo_wr_en,
  output logic         ready_a,
  output logic         ready_b,
  output logic [W-1:0] ofs_ae_b,
  output logic [W-1:0] ofs_ae_a,
  output logic [W-1:0] ofs_af_a,
  output logic [W-1:0] ofs_af_b
);
  localparam int unsigned TOTAL_BITS = NUM_OFS * W;
  localparam int unsigned CNT_W      = $clog2(TOTAL_BITS + 1);

  ofs_state_e       state_q, state_d;
  ofs_mode_e        mode_q, mode_d, dec_mode;
  logic [W-1:0]     dec_preset;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             rdy_a_q, rdy_a_d;
  logic             preset_en, word_en, bit_en;

  ofs_mode_decode #(.W(W)) u_decode (
    .prog_sel   (prog_sel),
    .fsel_hi    (fsel_hi),
    .fsel_lo    (fsel_lo),
    .mode       (dec_mode),
    .preset_val (dec_preset)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    cnt_d     = cnt_q;
    preset_en = 1'b0;
    word_en   = 1'b0;
    bit_en    = 1'b0;
    unique case (state_q)
      ST_CAPTURE: begin
        mode_d = dec_mode;
        cnt_d  = '0;
        unique case (dec_mode)
          MODE_P64, MODE_P16, MODE_P8: begin
            preset_en = 1'b1;
            state_d   = ST_DONE;
          end
          MODE_WORD: state_d = ST_WORD;
          MODE_BITS: state_d = ST_BITS;
          default:   state_d = ST_HALT;
        endcase
      end
      ST_WORD: begin
        if (wr_en_a && rdy_a_q) begin
          word_en = 1'b1;
          cnt_d   = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(NUM_OFS - 1)) state_d = ST_DONE;
        end
      end
      ST_BITS: begin
        if (!ser_en_n) begin
          bit_en = 1'b1;
          cnt_d  = cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(TOTAL_BITS - 1)) state_d = ST_DONE;
        end
      end
      default: ;
    endcase
    done_d  = (state_d == ST_DONE);
    rdy_a_d = (state_q == ST_WORD) || done_q;
  end

  // State registers
  always_ff @(posedge clk_a or negedge rst_a_n) begin
    if (!rst_a_n) begin
      state_q <= ST_CAPTURE;
      mode_q  <= MODE_RSV;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      rdy_a_q <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      rdy_a_q <= rdy_a_d;
    end
  end

  ofs_reg_bank #(.W(W)) u_bank (
    .clk        (clk_a),
    .rst_n      (rst_a_n),
    .preset_en  (preset_en),
    .preset_val (dec_preset),
    .word_en    (word_en),
    .word_idx   (cnt_q[1:0]),
    .word_data  (wr_data_a),
    .bit_en     (bit_en),
    .bit_in     (ser_din),
    .ofs_y1     (ofs_af_a),
    .ofs_x1     (ofs_ae_b),
    .ofs_y2     (ofs_af_b),
    .ofs_x2     (ofs_ae_a)
  );

  ofs_sync_stage #(.STAGES(2)) u_sync_b (
    .clk   (clk_b),
    .rst_n (rst_b_n),
    .d     (done_q),
    .q     (ready_b)
  );

  assign ready_a    = rdy_a_q;
  assign fifo_wr_en = wr_en_a & rdy_a_q & done_q;

  AST_MODE_FROZEN: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (state_q != ST_CAPTURE) |=> $stable(mode_q)); // R1
  AST_PRESET_HELD: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (done_q && mode_q == MODE_P64) |-> (ofs_af_a == W'(64) && ofs_ae_a == W'(64))); // R2
  AST_LOAD_NOT_FORWARDED: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    word_en |-> !fifo_wr_en); // R4
  AST_CNT_BOUND: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    cnt_q <= CNT_W'(TOTAL_BITS)); // R5
  AST_RDY_LOW_SERIAL: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (state_q == ST_BITS) |-> (!rdy_a_q && !fifo_wr_en)); // R6
  AST_HALT_STICKY: assert property (@(posedge clk_a) disable iff (!rst_a_n)
    (state_q == ST_HALT) |=> (state_q == ST_HALT && !rdy_a_q)); // R8
endmodule

// File: tb/ofs_prog_ctrl_tb_top.sv
`timescale 1ns/100ps
module ofs_prog_ctrl_tb_top;
  localparam int W = 8;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic rst_a_n = 1'b0, rst_b_n = 1'b0;
  logic prog_sel = 1'b0, fsel_hi = 1'b0, fsel_lo = 1'b0;
  logic wr_en_a = 1'b0, ser_din = 1'b0, ser_en_n = 1'b1;
  logic [W-1:0] wr_data_a = '0;
  logic fifo_wr_en, ready_a, ready_b;
  logic [W-1:0] ofs_ae_b, ofs_ae_a, ofs_af_a, ofs_af_b;

  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  ofs_prog_ctrl #(.W(W)) dut_i (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .clk_b(clk_b), .rst_b_n(rst_b_n),
    .prog_sel(prog_sel), .fsel_hi(fsel_hi), .fsel_lo(fsel_lo),
    .wr_en_a(wr_en_a), .wr_data_a(wr_data_a), .ser_din(ser_din), .ser_en_n(ser_en_n),
    .fifo_wr_en(fifo_wr_en), .ready_a(ready_a), .ready_b(ready_b),
    .ofs_ae_b(ofs_ae_b), .ofs_ae_a(ofs_ae_a), .ofs_af_a(ofs_af_a), .ofs_af_b(ofs_af_b)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: 0 capture, 1 word load, 2 serial load, 3 done, 4 halted
  int           m_st = 0;
  int           m_wr = 0;
  bit           m_rdy = 0;
  bit           m_bits[$];
  logic [W-1:0] m_y1 = '0, m_x1 = '0, m_y2 = '0, m_x2 = '0;
  string        m_tag = "R9 reset";

  always @(posedge clk_a or negedge rst_a_n) begin
    bit nrdy;
    if (!rst_a_n) begin
      m_st = 0; m_wr = 0; m_rdy = 0; m_bits.delete();
      m_y1 = '0; m_x1 = '0; m_y2 = '0; m_x2 = '0;
      m_tag = "R9 reset";
    end else begin
      nrdy = (m_st == 1 || m_st == 3);
      case (m_st)
        0: begin
          if (prog_sel && fsel_hi && fsel_lo) begin
            m_y1 = 64; m_x1 = 64; m_y2 = 64; m_x2 = 64; m_st = 3; m_tag = "R2 preset64";
          end else if (prog_sel && fsel_hi && !fsel_lo) begin
            m_y1 = 16; m_x1 = 16; m_y2 = 16; m_x2 = 16; m_st = 3; m_tag = "R2 preset16";
          end else if (prog_sel && !fsel_hi && fsel_lo) begin
            m_y1 = 8; m_x1 = 8; m_y2 = 8; m_x2 = 8; m_st = 3; m_tag = "R2 preset8";
          end else if (prog_sel) begin
            m_st = 1; m_tag = "R3 word load";
          end else if (fsel_hi && !fsel_lo) begin
            m_st = 2; m_tag = "R5 serial load";
          end else begin
            m_st = 4; m_tag = "R8 reserved";
          end
        end
        1: if (wr_en_a && m_rdy) begin
          case (m_wr)
            0: m_y1 = wr_data_a;
            1: m_x1 = wr_data_a;
            2: m_y2 = wr_data_a;
            default: m_x2 = wr_data_a;
          endcase
          m_wr++;
          if (m_wr == 4) m_st = 3;
        end
        2: if (!ser_en_n) begin
          m_bits.push_back(ser_din);
          if (m_bits.size() == 4 * W) begin
            for (int i = 0; i < W; i++) begin
              m_y1[W-1-i] = m_bits[i];
              m_x1[W-1-i] = m_bits[W+i];
              m_y2[W-1-i] = m_bits[2*W+i];
              m_x2[W-1-i] = m_bits[3*W+i];
            end
            m_st = 3;
          end
        end
        default: ;
      endcase
      m_rdy = nrdy;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk_a) begin
    #1;
    if (rst_a_n) begin
      if (m_st != 2) begin
        chk({m_tag, " ofs_af_a"}, ofs_af_a, m_y1);
        chk({m_tag, " ofs_ae_b"}, ofs_ae_b, m_x1);
        chk({m_tag, " ofs_af_b"}, ofs_af_b, m_y2);
        chk({m_tag, " ofs_ae_a"}, ofs_ae_a, m_x2);
      end
      chk("R6 ready_a", ready_a, m_rdy);
      chk("R4 fifo_wr_en", fifo_wr_en, wr_en_a && m_rdy && m_st == 3);
      if (m_st != 3) chk("R7 ready_b before done", ready_b, 0);
    end
  end

  // Port B ready latency window
  int bcnt = 0;
  always @(posedge clk_b) begin
    #1;
    if (rst_a_n && m_st == 3) bcnt++;
    else bcnt = 0;
    if (bcnt == 1) chk("R7 ready_b early", ready_b, 0);
    else if (bcnt >= 3 && bcnt < 8) chk("R7 ready_b late", ready_b, 1);
  end

  task automatic do_reset(input logic p, input logic h, input logic l);
    @(negedge clk_a);
    rst_a_n = 0; rst_b_n = 0;
    wr_en_a = 0; ser_en_n = 1;
    prog_sel = p; fsel_hi = h; fsel_lo = l;
    repeat (3) @(negedge clk_a);
    #1;
    chk("R9 reset ofs_af_a", ofs_af_a, 0);
    chk("R9 reset ofs_ae_a", ofs_ae_a, 0);
    chk("R9 reset ready_a", ready_a, 0);
    chk("R9 reset ready_b", ready_b, 0);
    chk("R9 reset fifo_wr_en", fifo_wr_en, 0);
    @(negedge clk_a);
    rst_a_n = 1; rst_b_n = 1;
  endtask

  task automatic wr(input logic [W-1:0] d);
    @(negedge clk_a);
    wr_en_a = 1; wr_data_a = d;
    @(negedge clk_a);
    wr_en_a = 0;
  endtask

  task automatic send_bits(input logic [4*W-1:0] v);
    for (int i = 4*W-1; i >= 0; i--) begin
      @(negedge clk_a);
      ser_en_n = 0; ser_din = v[i];
      if (i % 5 == 2) begin
        @(negedge clk_a);
        ser_en_n = 1; ser_din = ~v[i];
      end
    end
    @(negedge clk_a);
    ser_en_n = 1;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // Preset 64, then pin changes after capture (R1)
    do_reset(1, 1, 1);
    repeat (12) @(negedge clk_a);
    prog_sel = 0; fsel_hi = 0; fsel_lo = 0;
    repeat (6) @(negedge clk_a);
    #1;
    chk("R1 pins ignored ofs_af_b", ofs_af_b, 64);
    chk("R1 pins ignored ready_a", ready_a, 1);
    chk("R7 ready_b settled", ready_b, 1);
    wr(8'h5A); wr(8'hA5);

    // Preset 16 and 8 (R2)
    do_reset(1, 1, 0);
    repeat (12) @(negedge clk_a);
    #1 chk("R2 preset16 ofs_ae_b", ofs_ae_b, 16);
    do_reset(1, 0, 1);
    repeat (12) @(negedge clk_a);
    #1 chk("R2 preset8 ofs_ae_a", ofs_ae_a, 8);

    // Word loading (R3, R4), with early writes that must be dropped
    do_reset(1, 0, 0);
    wr_en_a = 1; wr_data_a = 8'h11;
    @(negedge clk_a);
    @(negedge clk_a);
    wr_en_a = 0;
    wr(8'hC8); wr(8'h05);
    repeat (3) @(negedge clk_a);
    wr(8'hFC); wr(8'h01);
    repeat (2) @(negedge clk_a);
    #1;
    chk("R3 word Y1 ofs_af_a", ofs_af_a, 8'hC8);
    chk("R3 word X1 ofs_ae_b", ofs_ae_b, 8'h05);
    chk("R3 word Y2 ofs_af_b", ofs_af_b, 8'hFC);
    chk("R3 word X2 ofs_ae_a", ofs_ae_a, 8'h01);
    wr(8'h77); wr(8'h33);
    @(negedge clk_a);
    wr_en_a = 1; wr_data_a = 8'h99;
    #1 chk("R4 forward after load", fifo_wr_en, 1);
    @(negedge clk_a);
    wr_en_a = 0;

    // Serial loading (R5, R6) with writes attempted during the stream
    do_reset(0, 1, 0);
    wr_en_a = 1; wr_data_a = 8'hEE;
    send_bits({8'hA5, 8'h3C, 8'h81, 8'h7E});
    wr_en_a = 0;
    repeat (10) @(negedge clk_a);
    #1;
    chk("R5 serial ofs_af_a", ofs_af_a, 8'hA5);
    chk("R5 serial ofs_ae_b", ofs_ae_b, 8'h3C);
    chk("R5 serial ofs_af_b", ofs_af_b, 8'h81);
    chk("R5 serial ofs_ae_a", ofs_ae_a, 8'h7E);
    chk("R6 ready_a after stream", ready_a, 1);

    // Reserved codes (R8)
    do_reset(0, 0, 0);
    wr(8'h42); wr(8'h43);
    send_bits(32'hFFFF_FFFF);
    repeat (4) @(negedge clk_a);
    #1;
    chk("R8 reserved ofs_af_a", ofs_af_a, 0);
    chk("R8 reserved ready_b", ready_b, 0);
    do_reset(0, 1, 1);
    wr(8'h42);
    repeat (8) @(negedge clk_a);
    #1 chk("R8 reserved ready_a", ready_a, 0);
    do_reset(0, 0, 1);
    repeat (8) @(negedge clk_a);
    #1 chk("R8 reserved ofs_ae_b", ofs_ae_b, 0);

    // Reset mid-stream, then preset (R9, R2)
    do_reset(0, 1, 0);
    send_bits(32'h1234_5678);
    do_reset(1, 1, 1);
    repeat (12) @(negedge clk_a);
    #1 chk("R2 preset after restart", ofs_af_a, 64);

    finish_run();
  end
endmodule